// File: doc/BRIEF.md
# Fixed Huffman literal/length decoder

This block turns a serial compressed bit stream into literal/length symbols using the static code of the DEFLATE format. It takes one bit per cycle under a valid/ready handshake. Code bits arrive with the most significant code bit first. Each complete code yields one 9-bit symbol, qualified by a valid strobe and by an error flag.

The first five bits of a code select one of four classes from a small table. The class fixes the total code length (7, 8 or 9 bits) and a signed offset. The decoder collects the rest of the bits and adds the offset to the raw code value, which gives the symbol. The symbol is registered and held until the consumer accepts it. While an accepted symbol is still pending, the input side is stalled.

Top module: `fixed_huff_litlen_dec`

## Requirements
- R1: While reset is asserted and directly after it, sym_valid_o is 0 and bit_ready_o is 1.
- R2: The 7-bit codes with raw values 0 to 23 (prefix 00000 to 00101) decode to symbol value + 256, giving 256 to 279, with sym_err_o = 0.
- R3: The 8-bit codes with raw values 48 to 191 (prefix 00110 to 10111) decode to value − 48, giving 0 to 143, with sym_err_o = 0.
- R4: The 8-bit codes with raw values 192 to 197 (prefix 11000) decode to value + 88, giving 280 to 285, with sym_err_o = 0.
- R5: The 9-bit codes with raw values 400 to 511 (prefix 11001 to 11111) decode to value − 256, giving 144 to 255, with sym_err_o = 0.
- R6: The 8-bit codes 198 and 199 are presented with sym_valid_o = 1 and sym_err_o = 1, and sym_o carries 286 or 287.
- R7: A bit is accepted on a clock edge where bit_valid_i and bit_ready_o are both 1, and bits are taken most significant code bit first. sym_valid_o goes high in the cycle after the edge that accepts the last bit of a code, and not earlier.
- R8: While sym_valid_o = 1 and sym_ready_i = 0, bit_ready_o is 0, and sym_o and sym_err_o stay unchanged.
- R9: Cycles with bit_valid_i = 0 are ignored whatever bit_i carries. A new code starts with the bit after the last bit of the previous code, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial code bit |
| bit_valid_i | input | 1 | bit_i carries a bit |
| bit_ready_o | output | 1 | Decoder accepts a bit this cycle |
| sym_o | output | 9 | Decoded literal/length symbol |
| sym_err_o | output | 1 | Symbol is one of the two reserved values |
| sym_valid_o | output | 1 | sym_o and sym_err_o are valid |
| sym_ready_i | input | 1 | Consumer takes the symbol |

## Verification
The stream is swept through every legal code of all four prefix classes, including the two reserved 8-bit codes. This pins down the length and offset of each class at its edges, for example raw 23 against 48, 191 against 192, and 197 against 198.

The sweep is run twice. The first pass has the consumer always ready and gap cycles with toggling bit_i between codes, which shows that invalid cycles are ignored. The second pass has a periodically stalling consumer, which shows that input is held off and output is held steady.

A directed case drives a 7-bit code bit by bit to place the valid edge exactly. A long stall shows that one pending symbol blocks the next code without being corrupted.

// File: rtl/fhd_pkg.sv
package fhd_pkg;
  localparam int SYM_W     = 9;
  localparam int MAX_LEN   = 9;
  localparam int PFX_W     = 5;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam int OFF_W     = SYM_W + 1;
  localparam int ERR_FIRST = 286;

  typedef logic [LEN_W-1:0]        len_t;
  typedef logic signed [OFF_W-1:0] off_t;

  typedef struct packed {
    len_t len;
    off_t off;
  } cls_t;

  // prefix class: code length and additive offset
  function automatic cls_t classify(int unsigned pfx);
    cls_t c;
    if (pfx <= 5) begin
      c.len = len_t'(7); c.off = off_t'(256);
    end else if (pfx <= 23) begin
      c.len = len_t'(8); c.off = -off_t'(48);
    end else if (pfx == 24) begin
      c.len = len_t'(8); c.off = off_t'(88);
    end else begin
      c.len = len_t'(9); c.off = -off_t'(256);
    end
    return c;
  endfunction
endpackage

// File: rtl/fhd_prefix_table.sv
module fhd_prefix_table
  import fhd_pkg::*;
#(
  parameter int P_W = PFX_W
) (
  input  logic [P_W-1:0] pfx_i,
  output cls_t           cls_o
);
  localparam int N = 1 << P_W;

  cls_t tab [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign tab[g] = classify(g);
  end

  assign cls_o = tab[pfx_i];
endmodule

// File: rtl/fhd_bit_accum.sv
module fhd_bit_accum
  import fhd_pkg::*;
#(
  parameter int L_W = MAX_LEN,
  parameter int P_W = PFX_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bit_i,
  input  logic           take_i,
  output logic           done_o,
  output logic [L_W-1:0] code_o,
  output off_t           off_o
);
  localparam int CNT_W = $clog2(L_W + 1);

  logic [L_W-1:0]   acc_q, acc_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  cls_t             cls_q, cls_tab;
  logic             at_pfx;

  assign acc_nx = {acc_q[L_W-2:0], bit_i};
  assign cnt_nx = cnt_q + CNT_W'(1);
  assign at_pfx = (cnt_q == CNT_W'(P_W - 1));

  fhd_prefix_table #(.P_W(P_W)) u_tab (
    .pfx_i (acc_nx[P_W-1:0]),
    .cls_o (cls_tab)
  );

  // class is latched once the prefix is complete; shortest code exceeds prefix
  assign done_o = take_i && (cnt_q >= CNT_W'(P_W)) && (cnt_nx == CNT_W'(cls_q.len));
  assign code_o = acc_nx;
  assign off_o  = cls_q.off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      cls_q <= '0;
    end else if (take_i) begin
      if (done_o) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_nx;
        cnt_q <= cnt_nx;
      end
      if (at_pfx) cls_q <= cls_tab;
    end
  end
endmodule

// File: rtl/fhd_sym_reg.sv
module fhd_sym_reg
  import fhd_pkg::*;
#(
  parameter int L_W = MAX_LEN,
  parameter int S_W = SYM_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [L_W-1:0] code_i,
  input  off_t           off_i,
  input  logic           out_ready_i,
  output logic [S_W-1:0] sym_o,
  output logic           err_o,
  output logic           valid_o
);
  off_t           sum;
  logic [S_W-1:0] sym_nx;

  assign sum    = off_t'($signed({1'b0, code_i})) + off_i;
  assign sym_nx = sum[S_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sym_o   <= '0;
      err_o   <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      sym_o   <= sym_nx;
      err_o   <= (sym_nx >= S_W'(ERR_FIRST));
    end else if (out_ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fixed_huff_litlen_dec.sv
module fixed_huff_litlen_dec
  import fhd_pkg::*;
#(
  parameter int L_W = MAX_LEN,
  parameter int P_W = PFX_W,
  parameter int S_W = SYM_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bit_i,
  input  logic           bit_valid_i,
  output logic           bit_ready_o,
  output logic [S_W-1:0] sym_o,
  output logic           sym_err_o,
  output logic           sym_valid_o,
  input  logic           sym_ready_i
);
  logic           take, done;
  logic [L_W-1:0] code;
  off_t           off;

  assign bit_ready_o = !sym_valid_o || sym_ready_i;
  assign take        = bit_valid_i && bit_ready_o;

  fhd_bit_accum #(.L_W(L_W), .P_W(P_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (bit_i),
    .take_i (take),
    .done_o (done),
    .code_o (code),
    .off_o  (off)
  );

  fhd_sym_reg #(.L_W(L_W), .S_W(S_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (done),
    .code_i      (code),
    .off_i       (off),
    .out_ready_i (sym_ready_i),
    .sym_o       (sym_o),
    .err_o       (sym_err_o),
    .valid_o     (sym_valid_o)
  );
endmodule

// File: rtl/fhd_checker.sv
module fhd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_i,
  input logic       bit_valid_i,
  input logic       bit_ready_o,
  input logic [8:0] sym_o,
  input logic       sym_err_o,
  input logic       sym_valid_o,
  input logic       sym_ready_i
);
  a_r8_block_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !sym_ready_i) |-> !bit_ready_o);

  a_r8_hold_symbol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !sym_ready_i) |=> (sym_valid_o && $stable(sym_o) && $stable(sym_err_o)));

  a_r6_symbol_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> (sym_o <= 9'd287));

  a_r7_valid_after_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sym_valid_o) |-> $past(bit_valid_i && bit_ready_o));

  a_r1_ready_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_o |-> bit_ready_o);
endmodule

bind fixed_huff_litlen_dec fhd_checker chk_i (.*);

// File: tb/fixed_huff_litlen_dec_tb_top.sv
`timescale 1ns/1ps
module fixed_huff_litlen_dec_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_ready_o;
  logic [8:0] sym_o;
  logic       sym_err_o;
  logic       sym_valid_o;
  logic       sym_ready_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int stall_mode = 0;
  int rcnt = 0;
  bit finished = 1'b0;
  logic [9:0] exp_q [$];

  always #2.5 clk_i = ~clk_i;

  fixed_huff_litlen_dec dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_of(input int code, input int len);
    int s;
    if (len == 7) s = code + 256;
    else if (len == 9) s = code - 256;
    else if (code >= 192) s = code + 88;
    else s = code - 48;
    return {(s >= 286), s[8:0]};
  endfunction

  function automatic string tag_of(input int s);
    if (s < 144) return "R3";
    if (s < 256) return "R5";
    if (s < 280) return "R2";
    if (s < 286) return "R4";
    return "R6";
  endfunction

  // consumer ready pattern
  always @(posedge clk_i) begin
    #1;
    rcnt++;
    if (stall_mode == 1) sym_ready_i = (rcnt % 3 == 0);
    else if (stall_mode == 2) sym_ready_i = 1'b0;
    else sym_ready_i = 1'b1;
  end

  task automatic send_bit(input logic b);
    bit_valid_i = 1'b1;
    bit_i = b;
    @(negedge clk_i);
    while (!bit_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1;
    bit_valid_i = 1'b0;
  endtask

  task automatic send_code(input int code, input int len);
    exp_q.push_back(exp_of(code, len));
    for (int i = len - 1; i >= 0; i--) send_bit(code[i]);
  endtask

  task automatic idle(input int n);
    bit_valid_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit_i = ~bit_i;
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic sweep(input int gaps);
    for (int c = 0; c < 24; c++) begin send_code(c, 7); if (gaps != 0) idle(c % 3); end
    for (int c = 48; c < 200; c++) begin send_code(c, 8); if (gaps != 0) idle(c % 3); end
    for (int c = 400; c < 512; c++) begin send_code(c, 9); if (gaps != 0) idle(c % 3); end
  endtask

  // scoreboard monitor
  logic       stalled_prev = 1'b0;
  logic [9:0] held_prev = '0;
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (stalled_prev)
        chk({sym_err_o, sym_o} == held_prev, "R8", int'({sym_err_o, sym_o}), int'(held_prev));
      if (sym_valid_o && !sym_ready_i)
        chk(bit_ready_o == 1'b0, "R8", int'(bit_ready_o), 0);
      stalled_prev = sym_valid_o && !sym_ready_i;
      held_prev = {sym_err_o, sym_o};
      if (sym_valid_o && sym_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", int'(sym_o), -1);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({sym_err_o, sym_o} == e, tag_of(int'(e[8:0])), int'({sym_err_o, sym_o}), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sym_valid_o == 1'b0, "R1", int'(sym_valid_o), 0);
    chk(bit_ready_o == 1'b1, "R1", int'(bit_ready_o), 1);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sym_valid_o == 1'b0, "R1", int'(sym_valid_o), 0);
    chk(bit_ready_o == 1'b1, "R1", int'(bit_ready_o), 1);
    @(posedge clk_i); #1;

    // R7: 7-bit code 0010111 (raw 23 -> 279), valid only after last bit
    exp_q.push_back(exp_of(23, 7));
    for (int i = 6; i >= 1; i--) send_bit(1'((23 >> i) & 1));
    chk(sym_valid_o == 1'b0, "R7", int'(sym_valid_o), 0);
    send_bit(1'b1);
    chk(sym_valid_o == 1'b1, "R7", int'(sym_valid_o), 1);
    chk(sym_o == 9'd279, "R7", int'(sym_o), 279);
    idle(3);

    // R9: full sweep with toggling gap cycles, consumer always ready
    sweep(1);
    idle(4);

    // R8: long stall with a second code pending
    stall_mode = 2;
    send_code(198, 8);
    idle(8);
    chk(sym_valid_o == 1'b1, "R8", int'(sym_valid_o), 1);
    chk(sym_err_o == 1'b1, "R6", int'(sym_err_o), 1);
    chk(sym_o == 9'd286, "R6", int'(sym_o), 286);
    chk(bit_ready_o == 1'b0, "R8", int'(bit_ready_o), 0);
    stall_mode = 0;
    send_code(400, 9);
    idle(3);

    // R8: back-to-back sweep with a periodically stalling consumer
    stall_mode = 1;
    sweep(0);
    stall_mode = 0;
    idle(10);

    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule